// File: doc/BRIEF.md
# Two-Channel Triggered Converter Code Register Block

This block sits between a simple register bus and a two-channel digital-to-analog converter. Each channel keeps a staging register that software writes and a live register that drives the converter's 12-bit code input. The staged value is copied to the live register at a chosen moment. That moment is either the next clock after the write, a software strobe, or a rising edge on one of seven external hardware trigger lines.

Each channel has its own enable, its own trigger-mode bit and a 4-bit source selector. Channel 2's control fields repeat channel 1's layout 16 bits higher in the same control word. External trigger lines are asynchronous to the block. They pass through a two-stage synchroniser and an edge detector before any channel sees them. The live registers can be read back over the bus but cannot be written.

Top module: `dac_trig_regs`

## Requirements
- R1: After reset every register reads zero and both code outputs are zero.
- R2: The control word is at byte offset 0x00. Channel 1 uses bit 0 as enable, bit 1 as trigger mode and bits [5:2] as source select. Channel 2 uses bits 16, 17 and [21:18] for the same fields. All other bits read zero, so writing all ones reads back 0x003F003F.
- R3: The staging registers are at 0x08 (channel 1) and 0x14 (channel 2). They keep write-data bits [11:0] and read back those 12 bits zero-extended.
- R4: With enable set and trigger mode clear, the live register takes the staging value one clock after the staging register changes.
- R5: With enable clear, a channel's live register and code output never change.
- R6: The strobe register is at 0x04. Bit 0 strobes channel 1 and bit 1 strobes channel 2. A strobe write only takes effect when the channel has enable set, trigger mode set and source select 0. It then reads back 1 for one cycle, the transfer happens on the next clock edge, and the bit reads back 0 afterwards. Otherwise the strobe write is ignored and the bit reads 0.
- R7: With trigger mode set and source select k (1 to 7), a rising edge on hw_trig_i[k-1] copies staging to live on the third clock edge after the input changes. A line held high does not trigger again, and the other lines have no effect.
- R8: Source select values 8 to 15 select nothing. With trigger mode set, no hardware line and no strobe changes the live register.
- R9: The live registers read at 0x2C (channel 1) and 0x30 (channel 2) and equal ch1_code_o and ch2_code_o. Writes to these offsets are ignored.
- R10: Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | ADDR_W (6) | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| hw_trig_i | input | 7 | Asynchronous hardware trigger lines |
| ch1_code_o | output | 12 | Channel 1 converter code |
| ch2_code_o | output | 12 | Channel 2 converter code |

## Verification
The assertions assume that each trigger line stays low long enough between pulses for the edge detector to re-arm. They also assume that bus writes are single-cycle strobes aligned to the clock. The bench drives every input at the falling edge. It holds each hardware pulse for four cycles and then keeps the line low for at least four cycles before the next pulse. It sweeps every source selector against the strobe and all seven lines on both channels, with the other channel disabled.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned CODE_W   = 12;
  localparam int unsigned NUM_HW   = 7;
  localparam int unsigned TSEL_W   = 4;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CH_SHIFT = 16;
  localparam int unsigned FIELD_W  = 2 + TSEL_W;

  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_STROBE = 'h04;
  localparam int unsigned OFS_HOLD1  = 'h08;
  localparam int unsigned OFS_HOLD2  = 'h14;
  localparam int unsigned OFS_LIVE1  = 'h2C;
  localparam int unsigned OFS_LIVE2  = 'h30;

  // packed MSB first: tsel at [5:2], ten at [1], en at [0]
  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic              ten;
    logic              en;
  } ch_ctrl_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned N      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  for (genvar b = 0; b < N; b++) begin : g_chk
    assert_edge_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_trig_pkg::*;
#(
  parameter int unsigned CW  = CODE_W,
  parameter int unsigned NHW = NUM_HW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ctrl_we_i,
  input  ch_ctrl_t       ctrl_i,
  input  logic           hold_we_i,
  input  logic [CW-1:0]  hold_i,
  input  logic           strobe_we_i,
  input  logic [NHW-1:0] hw_rise_i,
  output ch_ctrl_t       ctrl_o,
  output logic [CW-1:0]  hold_o,
  output logic [CW-1:0]  live_o,
  output logic           strobe_o
);
  ch_ctrl_t      ctrl_q;
  logic [CW-1:0] hold_q, live_q;
  logic          strobe_q;
  logic          sw_sel, armed, hw_hit, sw_hit, load;

  assign sw_sel = (ctrl_q.tsel == '0);
  assign armed  = ctrl_q.en & ctrl_q.ten;
  assign sw_hit = strobe_q & sw_sel;

  always_comb begin
    hw_hit = 1'b0;
    for (int k = 1; k <= NHW; k++)
      if (ctrl_q.tsel == TSEL_W'(k)) hw_hit = hw_rise_i[k-1];
  end

  assign load = ctrl_q.en & (ctrl_q.ten ? (sw_hit | hw_hit) : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      hold_q   <= '0;
      live_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_i;
      if (hold_we_i) hold_q <= hold_i;
      if (load)      live_q <= hold_q;
      // a pending strobe always clears; a new one needs the channel armed on source 0
      if (strobe_q)                              strobe_q <= 1'b0;
      else if (strobe_we_i && armed && sw_sel)   strobe_q <= 1'b1;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign hold_o   = hold_q;
  assign live_o   = live_q;
  assign strobe_o = strobe_q;

  assert_hold_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |=> $stable(live_q));
  assert_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && !ctrl_q.ten) |=> (live_q == $past(hold_q)));
  assert_strobe_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);
  assert_reserved_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && ctrl_q.ten && (ctrl_q.tsel > TSEL_W'(NHW))) |=> $stable(live_q));
endmodule

// File: rtl/dac_trig_regs.sv
module dac_trig_regs
  import dac_trig_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic [NUM_HW-1:0]   hw_trig_i,
  output logic [CODE_W-1:0]   ch1_code_o,
  output logic [CODE_W-1:0]   ch2_code_o
);
  logic              wr;
  logic [NUM_HW-1:0] hw_rise;
  ch_ctrl_t          ctrl_q   [NUM_CH];
  logic [CODE_W-1:0] hold_q   [NUM_CH];
  logic [CODE_W-1:0] live_q   [NUM_CH];
  logic [NUM_CH-1:0] strobe_q;
  logic              unused_wdata;

  assign wr = req_i & we_i;
  assign unused_wdata = ^{wdata_i[BUS_W-1:CH_SHIFT+FIELD_W],
                          wdata_i[CH_SHIFT-1:FIELD_W]};

  trig_sync #(.N(NUM_HW), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(hw_trig_i),
    .rise_o (hw_rise)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned HOLD_OFS = (ch == 0) ? OFS_HOLD1 : OFS_HOLD2;
    dac_chan i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_we_i  (wr && addr_i == ADDR_W'(OFS_CTRL)),
      .ctrl_i     (ch_ctrl_t'(wdata_i[ch*CH_SHIFT +: FIELD_W])),
      .hold_we_i  (wr && addr_i == ADDR_W'(HOLD_OFS)),
      .hold_i     (wdata_i[CODE_W-1:0]),
      .strobe_we_i(wr && addr_i == ADDR_W'(OFS_STROBE) && wdata_i[ch]),
      .hw_rise_i  (hw_rise),
      .ctrl_o     (ctrl_q[ch]),
      .hold_o     (hold_q[ch]),
      .live_o     (live_q[ch]),
      .strobe_o   (strobe_q[ch])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      for (int ch = 0; ch < NUM_CH; ch++) rdata_o[ch*CH_SHIFT +: FIELD_W] = ctrl_q[ch];
    end else if (addr_i == ADDR_W'(OFS_STROBE)) begin
      rdata_o[NUM_CH-1:0] = strobe_q;
    end else if (addr_i == ADDR_W'(OFS_HOLD1)) begin
      rdata_o[CODE_W-1:0] = hold_q[0];
    end else if (addr_i == ADDR_W'(OFS_HOLD2)) begin
      rdata_o[CODE_W-1:0] = hold_q[1];
    end else if (addr_i == ADDR_W'(OFS_LIVE1)) begin
      rdata_o[CODE_W-1:0] = live_q[0];
    end else if (addr_i == ADDR_W'(OFS_LIVE2)) begin
      rdata_o[CODE_W-1:0] = live_q[1];
    end
  end

  assign ch1_code_o = live_q[0];
  assign ch2_code_o = live_q[1];

  assert_live_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFS_LIVE1) && !ctrl_q[0].en) |=> $stable(ch1_code_o));
endmodule

// File: tb/test_dac_trig_regs.sv
module test_dac_trig_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  hw = '0;
  logic [11:0] c1, c2;
  int vec = 0, errs = 0;
  logic [11:0] m [2];

  always #(CLK_P/2) clk = ~clk;

  dac_trig_regs i_dac_trig_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hw_trig_i(hw),
    .ch1_code_o(c1), .ch2_code_o(c2)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic chk_rd(input string r, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(r, d, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_rd("R1 ctrl", 6'h00, 0);
    chk_rd("R1 strobe", 6'h04, 0);
    chk_rd("R1 hold1", 6'h08, 0);
    chk_rd("R1 hold2", 6'h14, 0);
    chk_rd("R1 live1", 6'h2C, 0);
    chk_rd("R1 live2", 6'h30, 0);
    chk("R1 code1", 32'(c1), 0);
    chk("R1 code2", 32'(c2), 0);
    // R10 unmapped
    chk_rd("R10 0x0C", 6'h0C, 0);
    chk_rd("R10 0x3C", 6'h3C, 0);
    // R2 layout mask; leaves both channels armed on reserved source 15
    wr(6'h00, 32'hFFFF_FFFF);
    chk_rd("R2 ctrl mask", 6'h00, 32'h003F_003F);
    // R3 hold keeps 12 bits
    wr(6'h08, 32'hFFFF_FABC);
    chk_rd("R3 hold1", 6'h08, 32'h0000_0ABC);
    // R8 reserved select: nothing fires
    hw = 7'h7F; idle(5); hw = '0; idle(4);
    wr(6'h04, 32'h3); idle(3);
    chk("R8 code1", 32'(c1), 0);
    chk("R8 code2", 32'(c2), 0);
    // R4 follow one clock after change
    wr(6'h00, 32'h0001_0001);
    chk("R4 code1 pre", 32'(c1), 0);
    idle(1);
    chk("R4 code1 post", 32'(c1), 32'hABC);
    wr(6'h14, 32'h123);
    chk("R4 code2 pre", 32'(c2), 0);
    idle(1);
    chk("R4 code2 post", 32'(c2), 32'h123);
    // R9 live registers read-only
    wr(6'h2C, 32'h555); wr(6'h30, 32'h666); idle(2);
    chk_rd("R9 live1", 6'h2C, 32'hABC);
    chk_rd("R9 live2", 6'h30, 32'h123);
    chk("R9 code1", 32'(c1), 32'hABC);
    // R5 disabled channel frozen
    wr(6'h00, 32'h0);
    wr(6'h08, 32'h777); idle(3);
    chk("R5 code1", 32'(c1), 32'hABC);
    wr(6'h04, 32'h3);
    chk_rd("R6 strobe ignored", 6'h04, 0);
    idle(2);
    chk("R5 code1 after strobe", 32'(c1), 32'hABC);
    // R6 strobe timing
    wr(6'h00, 32'h3);
    wr(6'h08, 32'h456);
    wr(6'h04, 32'h1);
    chk_rd("R6 strobe set", 6'h04, 32'h1);
    chk("R6 code1 pre", 32'(c1), 32'hABC);
    idle(1);
    chk("R6 code1 post", 32'(c1), 32'h456);
    chk_rd("R6 strobe clear", 6'h04, 0);
    // R7 latency and level behaviour, source 3
    wr(6'h00, 32'hF);
    wr(6'h08, 32'h321);
    hw[2] = 1'b1;
    idle(2);
    chk("R7 code1 edge2", 32'(c1), 32'h456);
    idle(1);
    chk("R7 code1 edge3", 32'(c1), 32'h321);
    wr(6'h08, 32'h999); idle(5);
    chk("R7 level no retrigger", 32'(c1), 32'h321);
    hw = '0; idle(4);
    // sweep all selectors against strobe and each line, both channels
    m[0] = 12'h321; m[1] = 12'h123;
    for (int ch = 0; ch < 2; ch++) begin
      for (int ts = 0; ts < 16; ts++) begin
        for (int src = 0; src < 8; src++) begin
          logic [11:0] v;
          string r;
          v = 12'((ch * 128 + ts * 8 + src) * 13 + 1);
          if (v == m[ch]) v = ~v;
          wr(6'h00, (32'h3 | 32'(ts << 2)) << (16 * ch));
          wr(ch == 0 ? 6'h08 : 6'h14, 32'(v));
          if (src == 0) wr(6'h04, 32'(1 << ch));
          else begin hw[src-1] = 1'b1; idle(4); hw = '0; end
          idle(4);
          if ((src == 0 && ts == 0) || (src != 0 && ts == src)) m[ch] = v;
          r = (ts > 7) ? "R8 sweep" : (src == 0 ? "R6 sweep" : "R7 sweep");
          if (ch == 1) r = {r, " R2 ch2"};
          chk(r, 32'(ch == 0 ? c1 : c2), 32'(m[ch]));
          chk("R5 other channel", 32'(ch == 0 ? c2 : c1), 32'(m[1-ch]));
        end
      end
    end
    chk_rd("R9 live1 final", 6'h2C, 32'(m[0]));
    chk_rd("R9 live2 final", 6'h30, 32'(m[1]));
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule